// File: doc/BRIEF.md
# Motorola-Format Track Packet Generator

This block drives a model-railway track line with a continuous stream of 18-bit train packets in the Motorola pulse-width format. Each data bit is one fixed-length period that starts high. A zero stays high for a short part of the period and a one for a long part; the rest of the period is low. Every packet goes out as two identical halves with an idle gap between them, followed by an inter-packet pause. The current packet is repeated until a replacement is committed. All timing advances only on cycles where the `tick` enable is high. At the default parameters `tick` is meant to run at 460.8 kHz.

Commands arrive as a byte stream with a valid/ready handshake. A byte is taken on every clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_last` marks the final byte of a command. The generator never applies back-pressure: `cmd_ready` is always high. A sender that needs to know whether a packet will be kept must watch `busy`. A packet command is held in a second buffer and becomes the active packet only when the current inter-packet pause ends. A pause command sets the pause length used by pauses that begin after it.

Top module: `mm_track_gen`

## Requirements
- R1: After reset, `busy` is low and `cmd_ready` is high. The line starts at the high start of bit 0 of the idle packet `IDLE_PKT` (default 18'h0C0F3), and that packet repeats until a packet command is committed.
- R2: Each bit lasts `BIT_TICKS` (96) ticks and is sent least significant bit first. A zero is 12 ticks high then 84 ticks low. A one is 84 ticks high then 12 ticks low.
- R3: A packet command is opcode 8'h01 followed by three data bytes. Packet bits [7:0] come from data byte 1, bits [15:8] from data byte 2, and bits [17:16] from bits [1:0] of data byte 3. Bits [7:2] of data byte 3 have no effect.
- R4: Both halves of a frame carry the same packet. After the 96-tick period of the first half's last bit, the line is held low for `INTRA_GAP`×8 ticks (default 688).
- R5: After the second half's last bit period, the line is held low for the pause. The next frame then starts and repeats the active packet.
- R6: A pause command is opcode 8'h02 followed by a 16-bit value, low byte first. The value is in units of 8 ticks and is clamped to `MAX_GAP` (347). It applies from the next pause that begins after the command.
- R7: A pause value equal to `UNIV_CODE` (0, the reset setting) selects alternating pauses. The k-th pause since reset lasts `MAX_GAP` units when k is odd and `SHORT_GAP` units (232) when k is even.
- R8: An accepted packet command raises `busy` on the clock edge that takes its last byte. The packet is first sent in the frame that follows the end of the current pause, and `busy` falls on that same edge.
- R9: A packet command that completes while `busy` is high is discarded.
- R10: Nothing changes for a packet command that is not exactly 4 bytes long, a pause command that is not exactly 3 bytes long, or any other opcode.
- R11: On cycles where `tick` is low, the line and all timing are frozen.
- R12: With `INVERT` set, the line is the exact complement of the non-inverted output at all times, including the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate enable; one tick is one waveform sample |
| cmd_valid | input | 1 | Command byte valid |
| cmd_data | input | 8 | Command byte |
| cmd_last | input | 1 | Marks the last byte of a command |
| cmd_ready | output | 1 | Byte accepted when high together with cmd_valid (always high) |
| busy | output | 1 | A pending packet is waiting; further packet commands are dropped |
| track_out | output | 1 | Track signal line |

## Verification
`busy` changes on the same edge that takes a command's last byte, so the bench reads it on the falling edge right after the byte is deasserted. A pause command changes only the pause that begins after it, and a packet only the frame after the next pause. For this reason each command is sent during the first bit of a frame, while a concurrent decoder reads that whole frame. With `tick` high every cycle, the decoder measures each high and low run in cycles at falling edges. It checks the high lengths (12 or 84), the 96-cycle bit periods, the gap and the pause from those runs, so no check depends on an absolute arrival time.

// File: rtl/mm_track_pkg.sv
package mm_track_pkg;

  typedef enum logic [1:0] {
    PH_HALF_A = 2'd0,
    PH_GAP    = 2'd1,
    PH_HALF_B = 2'd2,
    PH_PAUSE  = 2'd3
  } phase_t;

  localparam logic [7:0] OP_TRAIN = 8'h01;
  localparam logic [7:0] OP_PAUSE = 8'h02;
  localparam int         PKT_BITS = 18;

endpackage

// File: rtl/mm_cmd_parser.sv
module mm_cmd_parser
  import mm_track_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic                in_last,
  output logic                in_ready,
  output logic                pkt_wr,
  output logic [PKT_BITS-1:0] pkt_data,
  output logic                gap_wr,
  output logic [15:0]         gap_data
);

  logic [2:0] idx_q;   // byte position in the current command, saturating
  logic [7:0] op_q;
  logic [7:0] b1_q;
  logic [7:0] b2_q;
  logic       fire;

  assign in_ready = 1'b1;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      op_q  <= '0;
      b1_q  <= '0;
      b2_q  <= '0;
    end else if (fire) begin
      if (in_last)
        idx_q <= '0;
      else if (idx_q != 3'd7)
        idx_q <= idx_q + 3'd1;
      case (idx_q)
        3'd0:    op_q <= in_data;
        3'd1:    b1_q <= in_data;
        3'd2:    b2_q <= in_data;
        default: ;
      endcase
    end
  end

  // the final byte is used straight from the bus
  assign pkt_wr   = fire & in_last & (idx_q == 3'd3) & (op_q == OP_TRAIN);
  assign pkt_data = {in_data[1:0], b2_q, b1_q};
  assign gap_wr   = fire & in_last & (idx_q == 3'd2) & (op_q == OP_PAUSE);
  assign gap_data = {in_data, b1_q};

endmodule

// File: rtl/mm_pkt_buffer.sv
module mm_pkt_buffer
  import mm_track_pkg::*;
#(
  parameter logic [PKT_BITS-1:0] IDLE_PKT = 18'h0C0F3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [PKT_BITS-1:0] wr_data,
  input  logic                take,
  output logic [PKT_BITS-1:0] active,
  output logic                busy
);

  logic [PKT_BITS-1:0] pend_q;
  logic [PKT_BITS-1:0] act_q;
  logic                pvld_q;
  logic                accept;

  assign accept = wr & ~pvld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= IDLE_PKT;
      pvld_q <= 1'b0;
    end else begin
      if (take && pvld_q)
        act_q <= pend_q;
      if (accept)
        pend_q <= wr_data;
      pvld_q <= accept | (pvld_q & ~take);
    end
  end

  assign active = act_q;
  assign busy   = pvld_q;

endmodule

// File: rtl/mm_wave_seq.sv
module mm_wave_seq
  import mm_track_pkg::*;
#(
  parameter int          BIT_TICKS   = 96,
  parameter int          SHORT_TICKS = 12,
  parameter int          UNIT_TICKS  = 8,
  parameter int          INTRA_GAP   = 86,
  parameter int          MAX_GAP     = 347,
  parameter int          SHORT_GAP   = 232,
  parameter logic [15:0] UNIV_CODE   = 16'd0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PKT_BITS-1:0] pkt,
  input  logic                cfg_wr,
  input  logic [15:0]         cfg_val,
  output logic                take,
  output logic                level,
  output phase_t              phase,
  output logic [15:0]         pause_len
);

  localparam int LONG_TICKS = BIT_TICKS - SHORT_TICKS;
  localparam int MAX_SPAN   = MAX_GAP * UNIT_TICKS;
  localparam int GAP_SPAN   = INTRA_GAP * UNIT_TICKS;
  localparam int TOP_A      = (MAX_SPAN > GAP_SPAN) ? MAX_SPAN : GAP_SPAN;
  localparam int TOP_SPAN   = (TOP_A > BIT_TICKS) ? TOP_A : BIT_TICKS;
  localparam int CNT_W      = $clog2(TOP_SPAN + 1);
  localparam int IDX_W      = $clog2(PKT_BITS);

  phase_t           ph_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [CNT_W-1:0] limit;
  logic [IDX_W-1:0] bidx_q;
  logic [15:0]      cfg_q;
  logic [15:0]      len_q;
  logic             alt_q;
  logic             span_end;
  logic             last_bit;
  logic [CNT_W-1:0] thr;

  always_comb begin
    case (ph_q)
      PH_HALF_A, PH_HALF_B: limit = CNT_W'(BIT_TICKS - 1);
      PH_GAP:               limit = CNT_W'(GAP_SPAN - 1);
      default:              limit = CNT_W'(32'(len_q) * UNIT_TICKS - 1);
    endcase
  end

  assign span_end = (tcnt_q == limit);
  assign last_bit = (bidx_q == IDX_W'(PKT_BITS - 1));
  assign take     = tick & span_end & (ph_q == PH_PAUSE);

  // pause setting, clamped on entry
  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= UNIV_CODE;
    else if (cfg_wr)
      cfg_q <= (cfg_val != UNIV_CODE && cfg_val > 16'(MAX_GAP)) ? 16'(MAX_GAP) : cfg_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_HALF_A;
      tcnt_q <= '0;
      bidx_q <= '0;
      len_q  <= 16'(MAX_GAP);
      alt_q  <= 1'b0;
    end else if (tick) begin
      if (!span_end) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (ph_q)
          PH_HALF_A: begin
            if (last_bit) begin
              bidx_q <= '0;
              ph_q   <= PH_GAP;
            end else begin
              bidx_q <= bidx_q + 1'b1;
            end
          end
          PH_GAP: ph_q <= PH_HALF_B;
          PH_HALF_B: begin
            if (last_bit) begin
              bidx_q <= '0;
              ph_q   <= PH_PAUSE;
              alt_q  <= ~alt_q;
              if (cfg_q == UNIV_CODE)
                len_q <= alt_q ? 16'(SHORT_GAP) : 16'(MAX_GAP);
              else
                len_q <= cfg_q;
            end else begin
              bidx_q <= bidx_q + 1'b1;
            end
          end
          default: ph_q <= PH_HALF_A;
        endcase
      end
    end
  end

  assign thr   = pkt[bidx_q] ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
  assign level = ((ph_q == PH_HALF_A) || (ph_q == PH_HALF_B)) && (tcnt_q < thr);

  assign phase     = ph_q;
  assign pause_len = len_q;

endmodule

// File: rtl/mm_track_gen.sv
module mm_track_gen
  import mm_track_pkg::*;
#(
  parameter int                  BIT_TICKS   = 96,
  parameter int                  SHORT_TICKS = 12,
  parameter int                  UNIT_TICKS  = 8,
  parameter int                  INTRA_GAP   = 86,
  parameter int                  MAX_GAP     = 347,
  parameter int                  SHORT_GAP   = 232,
  parameter logic [15:0]         UNIV_CODE   = 16'd0,
  parameter logic [PKT_BITS-1:0] IDLE_PKT    = 18'h0C0F3,
  parameter bit                  INVERT      = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       cmd_ready,
  output logic       busy,
  output logic       track_out
);

  logic                pkt_wr_w;
  logic [PKT_BITS-1:0] pkt_data_w;
  logic                gap_wr_w;
  logic [15:0]         gap_data_w;
  logic [PKT_BITS-1:0] active_w;
  logic                take_w;
  logic                level_w;
  phase_t              phase_w;
  logic [15:0]         len_w;

  mm_cmd_parser u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_data  (cmd_data),
    .in_last  (cmd_last),
    .in_ready (cmd_ready),
    .pkt_wr   (pkt_wr_w),
    .pkt_data (pkt_data_w),
    .gap_wr   (gap_wr_w),
    .gap_data (gap_data_w)
  );

  mm_pkt_buffer #(.IDLE_PKT(IDLE_PKT)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (pkt_wr_w),
    .wr_data (pkt_data_w),
    .take    (take_w),
    .active  (active_w),
    .busy    (busy)
  );

  mm_wave_seq #(
    .BIT_TICKS   (BIT_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .UNIT_TICKS  (UNIT_TICKS),
    .INTRA_GAP   (INTRA_GAP),
    .MAX_GAP     (MAX_GAP),
    .SHORT_GAP   (SHORT_GAP),
    .UNIV_CODE   (UNIV_CODE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pkt       (active_w),
    .cfg_wr    (gap_wr_w),
    .cfg_val   (gap_data_w),
    .take      (take_w),
    .level     (level_w),
    .phase     (phase_w),
    .pause_len (len_w)
  );

  generate
    if (INVERT) begin : g_inv
      assign track_out = ~level_w;
    end else begin : g_pass
      assign track_out = level_w;
    end
  endgenerate

endmodule

// File: rtl/mm_track_gen_chk.sv
module mm_track_gen_chk
  import mm_track_pkg::*;
#(
  parameter bit INVERT  = 1'b0,
  parameter int MAX_GAP = 347
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        track_out,
  input logic        busy,
  input logic        take,
  input logic        pkt_wr,
  input phase_t      phase,
  input logic [15:0] len
);

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(track_out));

  // R4
  idle_in_gaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP || phase == PH_PAUSE) |-> (track_out == INVERT));

  // R8
  busy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> busy);

  // R9
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pkt_wr));

  // R6
  pause_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (len != 16'd0 && len <= 16'(MAX_GAP)));

endmodule

bind mm_track_gen mm_track_gen_chk #(.INVERT(INVERT), .MAX_GAP(MAX_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .track_out (track_out),
  .busy      (busy),
  .take      (take_w),
  .pkt_wr    (pkt_wr_w),
  .phase     (phase_w),
  .len       (len_w)
);

// File: tb/mm_track_gen_tb.sv
module mm_track_gen_tb;

  localparam int          BITT   = 96;
  localparam int          SHORTT = 12;
  localparam int          LONGT  = 84;
  localparam int          UNIT   = 8;
  localparam int          INTRA  = 86;
  localparam int          MAXG   = 347;
  localparam int          SHORTG = 232;
  localparam logic [17:0] IDLE   = 18'h0C0F3;
  localparam logic [17:0] P1     = 18'h23CA5;  // bytes A5 3C FE

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_last = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, busy, line;
  logic       cmd_ready_i, busy_i, line_i;

  int n_run = 0;
  int n_fail = 0;
  int inv_mism = 0;
  int pause_idx = 0;

  always #5 clk = ~clk;

  mm_track_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .busy(busy), .track_out(line)
  );

  mm_track_gen #(.INVERT(1'b1)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready_i),
    .busy(busy_i), .track_out(line_i)
  );

  // R12 monitor
  always @(negedge clk) if (rst_n && (line_i !== ~line)) inv_mism++;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic int univ_len(input int k);
    return (k % 2 == 1) ? MAXG : SHORTG;
  endfunction

  task automatic send_cmd(input int len, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic [7:0] d, input logic [7:0] e);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_last  = (i == len - 1);
      case (i)
        0: cmd_data = a;
        1: cmd_data = b;
        2: cmd_data = c;
        3: cmd_data = d;
        default: cmd_data = e;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_last  = 1'b0;
  endtask

  // starts at the sample where a half's first bit is high
  task automatic read_half(output logic [17:0] bits, output int tail, output int bad);
    bad = 0;
    tail = 0;
    bits = '0;
    for (int i = 0; i < 18; i++) begin
      int hi = 0;
      int lo = 0;
      while (line) begin hi++; @(negedge clk); end
      while (!line) begin lo++; @(negedge clk); end
      bits[i] = (hi == LONGT);
      if (hi != LONGT && hi != SHORTT) bad++;
      if (i < 17) begin
        if (hi + lo != BITT) bad++;
      end else begin
        tail = lo - (BITT - hi);
      end
    end
  endtask

  task automatic read_frame(output logic [17:0] h1, output logic [17:0] h2,
                            output int gap, output int pause, output int bad);
    int b1, b2;
    read_half(h1, gap, b1);
    read_half(h2, pause, b2);
    bad = b1 + b2;
    pause_idx++;
  endtask

  task automatic t_reset;
    int moved = 0;
    rst_n = 1'b0;
    tick  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "busy after reset", busy, 0);
    check("R1", "cmd_ready after reset", cmd_ready, 1);
    check("R1", "line starts high", line, 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (line !== 1'b1) moved++;
    end
    check("R11", "line changes without tick", moved, 0);
    tick = 1'b1;
  endtask

  task automatic t_idle_frame;
    logic [17:0] h1, h2;
    int gap, pause, bad;
    read_frame(h1, h2, gap, pause, bad);
    check("R2", "bit shape errors", bad, 0);
    check("R1", "first half is idle packet", int'(h1), int'(IDLE));
    check("R4", "second half equals first", int'(h2), int'(h1));
    check("R4", "intra gap ticks", gap, INTRA * UNIT);
    check("R7", "first universal pause", pause, univ_len(pause_idx) * UNIT);
  endtask

  task automatic t_pause_cmd(input logic [15:0] v, input int exp_units, input string req);
    logic [17:0] h1, h2;
    int gap, pause, bad;
    fork
      read_frame(h1, h2, gap, pause, bad);
      send_cmd(3, 8'h02, v[7:0], v[15:8], 8'h00, 8'h00);
    join
    check(req, "pause after pause command", pause, exp_units * UNIT);
    check("R2", "bit shape errors", bad, 0);
  endtask

  task automatic t_malformed;
    logic [17:0] h1, h2;
    int gap, pause, bad;
    fork
      read_frame(h1, h2, gap, pause, bad);
      begin
        send_cmd(3, 8'h01, 8'h11, 8'h22, 8'h00, 8'h00);
        send_cmd(5, 8'h01, 8'h11, 8'h22, 8'h03, 8'h44);
        send_cmd(4, 8'h07, 8'h11, 8'h22, 8'h03, 8'h00);
        send_cmd(4, 8'h02, 8'h64, 8'h00, 8'h00, 8'h00);
        check("R10", "busy after malformed commands", busy, 0);
      end
    join
    check("R10", "packet unchanged", int'(h1), int'(IDLE));
    check("R10", "pause unchanged", pause, univ_len(pause_idx) * UNIT);
  endtask

  task automatic t_double_buffer;
    logic [17:0] h1, h2;
    int gap, pause, bad;
    fork
      read_frame(h1, h2, gap, pause, bad);
      begin
        send_cmd(4, 8'h01, 8'hA5, 8'h3C, 8'hFE, 8'h00);
        check("R8", "busy after packet accepted", busy, 1);
        send_cmd(4, 8'h01, 8'h11, 8'h22, 8'h03, 8'h00);
        check("R9", "busy after refused packet", busy, 1);
      end
    join
    check("R8", "old packet kept until pause end", int'(h2), int'(IDLE));
    check("R8", "busy cleared at new frame", busy, 0);
    read_frame(h1, h2, gap, pause, bad);
    check("R3", "new packet first half", int'(h1), int'(P1));
    check("R9", "second half is first packet", int'(h2), int'(P1));
    check("R2", "bit shape errors", bad, 0);
    check("R5", "pause length", pause, univ_len(pause_idx) * UNIT);
    read_frame(h1, h2, gap, pause, bad);
    check("R5", "packet repeats", int'(h1), int'(P1));
    check("R4", "intra gap ticks", gap, INTRA * UNIT);
    check("R7", "alternating pause", pause, univ_len(pause_idx) * UNIT);
  endtask

  initial begin
    t_reset();
    t_idle_frame();
    t_pause_cmd(16'd100, 100, "R6");
    t_pause_cmd(16'h1234, MAXG, "R6");
    t_pause_cmd(16'd0, univ_len(4), "R7");
    t_malformed();
    t_double_buffer();
    check("R12", "inverted output mismatches", inv_mism, 0);
    summary();
  end

endmodule